// File: doc/BRIEF.md
# Graphics Method Notifier Controller

This block sits behind a graphics command queue and consumes one method at a time. Each method carries an offset, a 32-bit parameter, a 5-bit object class and the instance offset of its object. Offsets above the set-notify offset (0x104) belong to a class. The block passes them on as a one-cycle dispatch strobe that carries the class, the parameter and the object descriptor base address. Offsets at or below 0x104 are generic methods that every class shares. Of these, only set-notify is implemented, and the rest are flagged as invalid.

Set-notify arms a single pending notification. After the next method that is not a set-notify has run, the block looks at the armed notifier word. A non-zero request type there raises a software-notify interrupt. A zero request type asks an external DMA engine to write the notification record and waits for its acknowledge. If a second set-notify arrives while one is still armed, the block raises a double-notify error and cancels the armed notify. The errors and the software notify land in two sticky interrupt status registers. Each register has an enable mask and is cleared by writing ones.

Top module: `gfx_notify_ctrl`

## Requirements
- R1: After reset, m_ready is 1, and pend_o, notif_o, stat0_o, stat1_o, irq_o and dma_req are all 0.
- R2: A method whose offset is above 0x104 produces a cls_stb pulse in the cycle after acceptance. In that cycle cls_id, cls_offset and cls_param equal the method's fields, and cls_base equals m_inst shifted left by 4.
- R3: A set-notify method (offset 0x104) accepted while no notify is pending copies m_param into notif_o and sets pend_o. No notification check follows that method.
- R4: A set-notify method accepted while a notify is pending sets stat1_o bit 4 (double notify) and clears pend_o. The new parameter is discarded, so notif_o keeps its value.
- R5: A method with an offset below 0x104 sets stat1_o bit 0 (invalid method) and causes no dispatch.
- R6: A method that is not a set-notify, accepted while no notify is pending, leaves pend_o, stat0_o and dma_req unchanged.
- R7: After a method that is not a set-notify, if a notify is pending and notifier bits 22:20 are non-zero, the block sets stat0_o bit 28 and clears pend_o one cycle after the method's acceptance cycle.
- R8: If those bits are zero, dma_req is raised one cycle after the acceptance cycle, with dma_inst equal to notifier bits 15:0. Both hold until dma_ack, and pend_o clears on the acknowledged cycle.
- R9: m_ready is 1 only when the block is idle. No method is accepted while dma_req is high.
- R10: Status bits are sticky. A csr_we write clears the bits set in csr_wdata: csr_sel 0 clears in stat0_o and csr_sel 1 clears in stat1_o.
- R11: A csr_we write with csr_sel 2 or 3 loads enable register 0 or 1. irq_o is the OR of both status registers ANDed with their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Method offered |
| m_ready | output | 1 | Block idle, method taken on valid and ready |
| m_offset | input | OFS_W | Method offset |
| m_param | input | DATA_W | Method parameter |
| m_class | input | CLS_W | Object class |
| m_inst | input | INST_W | Object instance offset in 16-byte units |
| cls_stb | output | 1 | Class-specific method dispatch strobe |
| cls_id | output | CLS_W | Class of the dispatched method |
| cls_offset | output | OFS_W | Offset of the dispatched method |
| cls_param | output | DATA_W | Parameter of the dispatched method |
| cls_base | output | INST_W+4 | Object descriptor byte base address |
| dma_req | output | 1 | Hardware notification write request |
| dma_inst | output | INST_W | Notifier instance for the request |
| dma_ack | input | 1 | Request accepted by the DMA engine |
| csr_we | input | 1 | Interrupt register write |
| csr_sel | input | 2 | 0/1 clear status 0/1, 2/3 load enable 0/1 |
| csr_wdata | input | DATA_W | Write data |
| stat0_o | output | DATA_W | Interrupt status 0 |
| stat1_o | output | DATA_W | Interrupt status 1 |
| irq_o | output | 1 | Combined enabled interrupt |
| pend_o | output | 1 | Notify armed |
| notif_o | output | DATA_W | Current notifier word |

## Verification
The bench uses several method streams: class offsets spread over the whole range above 0x104, invalid generic offsets below it, and set-notify parameters whose request type is forced to zero about half the time. Class-only streams show that dispatch never touches notify state. Set-notify followed by a class method tells the software path apart from the hardware path. Two set-notify methods in a row expose the double-notify cancel. The bench also holds a method at the input during an outstanding DMA request, and random acknowledge delays plus mixed clear and enable writes check that the status bits are sticky and that the interrupt mask works.

// File: rtl/gmn_pkg.sv
package gmn_pkg;
   typedef enum logic [1:0] {SQ_IDLE, SQ_CHECK, SQ_WAIT} sq_state_t;
   typedef enum logic [1:0] {MK_CLASS, MK_SETNTF, MK_BADGEN} mkind_t;

   localparam int SW_NTF_BIT     = 28;
   localparam int BAD_METHOD_BIT = 0;
   localparam int DBL_NTF_BIT    = 4;
   localparam int RQ_TYPE_LSB    = 20;
   localparam int RQ_TYPE_W      = 3;
endpackage

// File: rtl/gmn_decode.sv
module gmn_decode
   import gmn_pkg::*;
#(
   parameter int OFS_W   = 13,
   parameter int SET_OFS = 'h104
) (
   input  logic [OFS_W-1:0] ofs,
   output mkind_t           kind
);
   localparam logic [OFS_W-1:0] SET_V = OFS_W'(SET_OFS);

   always_comb begin
      if (ofs > SET_V)       kind = MK_CLASS;
      else if (ofs == SET_V) kind = MK_SETNTF;
      else                   kind = MK_BADGEN;
   end
endmodule

// File: rtl/gmn_seq.sv
module gmn_seq
   import gmn_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int INST_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m_valid,
   input  mkind_t            kind,
   input  logic [DATA_W-1:0] param,
   input  logic              dma_ack,
   output logic              m_ready,
   output logic              accept,
   output logic              dma_req,
   output logic [INST_W-1:0] dma_inst,
   output logic              pend,
   output logic [DATA_W-1:0] word,
   output logic              sw_hit,
   output logic              bad_hit,
   output logic              dbl_hit
);
   sq_state_t             st, st_n;
   logic                  pend_n;
   logic [DATA_W-1:0]     word_n;
   logic [RQ_TYPE_W-1:0]  rq_type;

   assign rq_type  = word[RQ_TYPE_LSB +: RQ_TYPE_W];
   assign m_ready  = (st == SQ_IDLE);
   assign accept   = m_valid && m_ready;
   assign bad_hit  = accept && (kind == MK_BADGEN);
   assign dbl_hit  = accept && (kind == MK_SETNTF) && pend;
   assign sw_hit   = (st == SQ_CHECK) && pend && (rq_type != '0);
   assign dma_req  = (st == SQ_WAIT);
   assign dma_inst = word[INST_W-1:0];

   always_comb begin
      st_n   = st;
      pend_n = pend;
      word_n = word;
      unique case (st)
         SQ_IDLE: if (accept) begin
            if (kind == MK_SETNTF) begin
               if (pend) pend_n = 1'b0;
               else begin
                  pend_n = 1'b1;
                  word_n = param;
               end
            end else begin
               st_n = SQ_CHECK;
            end
         end
         SQ_CHECK: begin
            if (!pend) st_n = SQ_IDLE;
            else if (rq_type != '0) begin
               pend_n = 1'b0;
               st_n   = SQ_IDLE;
            end else begin
               st_n = SQ_WAIT;
            end
         end
         SQ_WAIT: if (dma_ack) begin
            pend_n = 1'b0;
            st_n   = SQ_IDLE;
         end
         default: st_n = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         pend <= 1'b0;
         word <= '0;
      end else begin
         st   <= st_n;
         pend <= pend_n;
         word <= word_n;
      end
   end
endmodule

// File: rtl/gmn_irq_bank.sv
module gmn_irq_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         w1c_we,
   input  logic         en_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] stat_o,
   output logic         hit_o
);
   logic [W-1:0] en_q;
   logic [W-1:0] clr;

   assign clr   = w1c_we ? wdata : '0;
   assign hit_o = |(stat_o & en_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_o <= '0;
         en_q   <= '0;
      end else begin
         stat_o <= (stat_o & ~clr) | set_i;
         if (en_we) en_q <= wdata;
      end
   end
endmodule

// File: rtl/gfx_notify_ctrl.sv
module gfx_notify_ctrl
   import gmn_pkg::*;
#(
   parameter int OFS_W        = 13,
   parameter int CLS_W        = 5,
   parameter int DATA_W       = 32,
   parameter int INST_W       = 16,
   parameter int SET_OFS      = 'h104,
   parameter bit REG_DISPATCH = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                m_valid,
   output logic                m_ready,
   input  logic [OFS_W-1:0]    m_offset,
   input  logic [DATA_W-1:0]   m_param,
   input  logic [CLS_W-1:0]    m_class,
   input  logic [INST_W-1:0]   m_inst,
   output logic                cls_stb,
   output logic [CLS_W-1:0]    cls_id,
   output logic [OFS_W-1:0]    cls_offset,
   output logic [DATA_W-1:0]   cls_param,
   output logic [INST_W+3:0]   cls_base,
   output logic                dma_req,
   output logic [INST_W-1:0]   dma_inst,
   input  logic                dma_ack,
   input  logic                csr_we,
   input  logic [1:0]          csr_sel,
   input  logic [DATA_W-1:0]   csr_wdata,
   output logic [DATA_W-1:0]   stat0_o,
   output logic [DATA_W-1:0]   stat1_o,
   output logic                irq_o,
   output logic                pend_o,
   output logic [DATA_W-1:0]   notif_o
);
   localparam int BASE_W = INST_W + 4;

   if (DATA_W < RQ_TYPE_LSB + RQ_TYPE_W || DATA_W <= SW_NTF_BIT) begin : g_bad_data_w
      $error("DATA_W too narrow for notifier fields");
   end
   if (INST_W > DATA_W) begin : g_bad_inst_w
      $error("INST_W must not exceed DATA_W");
   end
   if (SET_OFS >= (1 << OFS_W)) begin : g_bad_set_ofs
      $error("SET_OFS does not fit in OFS_W");
   end

   mkind_t            kind;
   logic              accept, sw_hit, bad_hit, dbl_hit, hit0, hit1;
   logic [DATA_W-1:0] set0, set1;
   logic              cls_go;

   gmn_decode #(.OFS_W(OFS_W), .SET_OFS(SET_OFS)) u_dec (
      .ofs  (m_offset),
      .kind (kind)
   );

   gmn_seq #(.DATA_W(DATA_W), .INST_W(INST_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .m_valid  (m_valid),
      .kind     (kind),
      .param    (m_param),
      .dma_ack  (dma_ack),
      .m_ready  (m_ready),
      .accept   (accept),
      .dma_req  (dma_req),
      .dma_inst (dma_inst),
      .pend     (pend_o),
      .word     (notif_o),
      .sw_hit   (sw_hit),
      .bad_hit  (bad_hit),
      .dbl_hit  (dbl_hit)
   );

   always_comb begin
      set0 = '0;
      set1 = '0;
      set0[SW_NTF_BIT]     = sw_hit;
      set1[BAD_METHOD_BIT] = bad_hit;
      set1[DBL_NTF_BIT]    = dbl_hit;
   end

   gmn_irq_bank #(.W(DATA_W)) u_irq0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set0),
      .w1c_we (csr_we && csr_sel == 2'd0),
      .en_we  (csr_we && csr_sel == 2'd2),
      .wdata  (csr_wdata),
      .stat_o (stat0_o),
      .hit_o  (hit0)
   );

   gmn_irq_bank #(.W(DATA_W)) u_irq1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set1),
      .w1c_we (csr_we && csr_sel == 2'd1),
      .en_we  (csr_we && csr_sel == 2'd3),
      .wdata  (csr_wdata),
      .stat_o (stat1_o),
      .hit_o  (hit1)
   );

   assign irq_o  = hit0 | hit1;
   assign cls_go = accept && (kind == MK_CLASS);

   if (REG_DISPATCH) begin : g_disp_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cls_stb    <= 1'b0;
            cls_id     <= '0;
            cls_offset <= '0;
            cls_param  <= '0;
            cls_base   <= '0;
         end else begin
            cls_stb <= cls_go;
            if (cls_go) begin
               cls_id     <= m_class;
               cls_offset <= m_offset;
               cls_param  <= m_param;
               cls_base   <= {m_inst, 4'b0000};
            end
         end
      end
   end else begin : g_disp_comb
      assign cls_stb    = cls_go;
      assign cls_id     = m_class;
      assign cls_offset = m_offset;
      assign cls_param  = m_param;
      assign cls_base   = BASE_W'({m_inst, 4'b0000});
   end
endmodule

// File: rtl/gmn_chk.sv
module gmn_chk #(
   parameter int OFS_W        = 13,
   parameter int DATA_W       = 32,
   parameter int INST_W       = 16,
   parameter int SET_OFS      = 'h104,
   parameter bit REG_DISPATCH = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_valid,
   input logic              m_ready,
   input logic [OFS_W-1:0]  m_offset,
   input logic              cls_stb,
   input logic              dma_req,
   input logic              dma_ack,
   input logic [INST_W-1:0] dma_inst,
   input logic              pend_o,
   input logic [DATA_W-1:0] stat1_o
);
   localparam logic [OFS_W-1:0] SET_V = OFS_W'(SET_OFS);

   // R9
   dma_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> !m_ready);

   // R8
   dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !dma_ack |=> dma_req && $stable(dma_inst));

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && dma_ack |=> !pend_o && !dma_req);

   // R3
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_ready && m_offset == SET_V && !pend_o |=> pend_o);

   // R5
   bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat1_o[0]) |-> $past(m_valid && m_ready && m_offset < SET_V));

   if (REG_DISPATCH) begin : g_reg
      // R2
      dispatch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cls_stb |-> $past(m_valid && m_ready && m_offset > SET_V));
   end else begin : g_comb
      // R2
      dispatch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cls_stb |-> m_valid && m_ready && m_offset > SET_V);
   end
endmodule

bind gfx_notify_ctrl gmn_chk #(
   .OFS_W(OFS_W), .DATA_W(DATA_W), .INST_W(INST_W),
   .SET_OFS(SET_OFS), .REG_DISPATCH(REG_DISPATCH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
   .m_offset(m_offset), .cls_stb(cls_stb), .dma_req(dma_req),
   .dma_ack(dma_ack), .dma_inst(dma_inst), .pend_o(pend_o), .stat1_o(stat1_o)
);

// File: tb/sim_gfx_notify_ctrl.sv
module sim_gfx_notify_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [12:0] SET = 13'h104;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        m_valid = 1'b0, m_ready;
   logic [12:0] m_offset = '0;
   logic [31:0] m_param = '0;
   logic [4:0]  m_class = '0;
   logic [15:0] m_inst = '0;
   logic        cls_stb;
   logic [4:0]  cls_id;
   logic [12:0] cls_offset;
   logic [31:0] cls_param;
   logic [19:0] cls_base;
   logic        dma_req, dma_ack = 1'b0;
   logic [15:0] dma_inst;
   logic        csr_we = 1'b0;
   logic [1:0]  csr_sel = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] stat0_o, stat1_o, notif_o;
   logic        irq_o, pend_o;

   int errors = 0, checks = 0;
   bit          e_pend = 0;
   logic [31:0] e_word = '0, s0 = '0, s1 = '0, e0 = '0, e1 = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gfx_notify_ctrl u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic bit exp_irq();
      return (|(s0 & e0)) || (|(s1 & e1));
   endfunction

   task automatic compare_all(input string req);
      chk(pend_o == e_pend, {req, " pend"}, 32'(pend_o), 32'(e_pend));
      chk(notif_o == e_word, {req, " notifier"}, notif_o, e_word);
      chk(stat0_o == s0, {req, " stat0"}, stat0_o, s0);
      chk(stat1_o == s1, {req, " stat1"}, stat1_o, s1);
      chk(irq_o == exp_irq(), "R11 irq", 32'(irq_o), 32'(exp_irq()));
      chk(m_ready == 1'b1, "R9 ready idle", 32'(m_ready), 32'd1);
   endtask

   task automatic csr_wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
      case (sel)
         2'd0: s0 &= ~d;
         2'd1: s1 &= ~d;
         2'd2: e0 = d;
         default: e1 = d;
      endcase
      compare_all("R10 csr");
   endtask

   task automatic send(input logic [12:0] ofs, input logic [31:0] prm, input logic [4:0] cl,
                       input logic [15:0] inst, input int ack_dly, input bit stall);
      @(negedge clk);
      m_valid = 1'b1; m_offset = ofs; m_param = prm; m_class = cl; m_inst = inst;
      while (!m_ready) @(negedge clk);
      @(negedge clk);
      m_valid = 1'b0;
      if (ofs > SET) begin
         chk(cls_stb && cls_id == cl && cls_param == prm && cls_offset == ofs,
             "R2 dispatch", cls_param, prm);
         chk(cls_base == {inst, 4'b0000}, "R2 base", 32'(cls_base), 32'({inst, 4'b0000}));
      end else begin
         chk(!cls_stb, "R5 no dispatch", 32'(cls_stb), 32'd0);
      end
      if (ofs == SET) begin
         if (e_pend) begin s1[4] = 1'b1; e_pend = 0; end
         else begin e_pend = 1; e_word = prm; end
         compare_all(e_pend ? "R3 arm" : "R4 double");
      end else begin
         if (ofs < SET) s1[0] = 1'b1;
         @(negedge clk);
         if (e_pend && e_word[22:20] != 3'd0) begin
            s0[28] = 1'b1; e_pend = 0;
            chk(!dma_req, "R7 no dma", 32'(dma_req), 32'd0);
            compare_all("R7 soft");
         end else if (e_pend) begin
            chk(dma_req && dma_inst == e_word[15:0], "R8 dma req", 32'(dma_inst), 32'(e_word[15:0]));
            chk(!m_ready, "R9 busy", 32'(m_ready), 32'd0);
            if (stall) begin
               m_valid = 1'b1; m_offset = 13'h010;
               repeat (3) @(negedge clk);
               chk(!m_ready && stat1_o == s1 && !cls_stb, "R9 held off", stat1_o, s1);
               m_valid = 1'b0;
            end
            repeat (ack_dly) @(negedge clk);
            chk(dma_req && pend_o, "R8 held", 32'(dma_req), 32'd1);
            dma_ack = 1'b1;
            @(negedge clk);
            dma_ack = 1'b0;
            e_pend = 0;
            chk(!dma_req, "R8 released", 32'(dma_req), 32'd0);
            compare_all("R8 hard");
         end else begin
            chk(!dma_req, "R6 no dma", 32'(dma_req), 32'd0);
            compare_all("R6 idle check");
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!dma_req && !cls_stb, "R1 reset outputs", 32'(dma_req), 32'd0);
      compare_all("R1 reset");

      // directed corners
      send(13'h200, 32'h1234_5678, 5'd7, 16'h0abc, 0, 0);          // R2, R6
      send(13'h1ffc, 32'hdead_beef, 5'd31, 16'hffff, 0, 0);        // R2 top offset
      send(13'h105, 32'h1, 5'd1, 16'h1, 0, 0);                     // R2 just above
      send(13'h000, 32'h0, 5'd2, 16'h0, 0, 0);                     // R5
      send(13'h100, 32'h0, 5'd2, 16'h0, 0, 0);                     // R5
      send(SET, 32'h0030_0011, 5'd3, 16'h0, 0, 0);                 // R3 soft type 3
      send(13'h300, 32'h5, 5'd3, 16'h2, 0, 0);                     // R7
      send(SET, 32'h0001_beef, 5'd3, 16'h0, 0, 0);                 // R3 hw
      send(13'h000, 32'h0, 5'd3, 16'h0, 2, 1);                     // R8, R9 stall
      send(SET, 32'h0010_0001, 5'd3, 16'h0, 0, 0);                 // R3
      send(SET, 32'h0070_9999, 5'd3, 16'h0, 0, 0);                 // R4 discard
      send(13'h400, 32'h0, 5'd3, 16'h0, 0, 0);                     // R6 after cancel
      csr_wr(2'd3, 32'h0000_0011);                                 // R11 enable
      csr_wr(2'd1, 32'h0000_0001);                                 // R10 clear bit 0
      csr_wr(2'd1, 32'h0000_0010);                                 // R10 clear bit 4
      csr_wr(2'd2, 32'h1000_0000);                                 // R11
      csr_wr(2'd0, 32'hffff_ffff);                                 // R10

      for (int i = 0; i < 300; i++) begin
         int r;
         r = $urandom % 12;
         if (r < 4)
            send(13'(13'h108 + ($urandom % 13'h1ef8)), $urandom, 5'($urandom), 16'($urandom), 0, 0);
         else if (r < 6)
            send(13'($urandom % 32'h104), $urandom, 5'($urandom), 16'($urandom), 0, 0);
         else if (r < 10) begin
            logic [31:0] p;
            p = $urandom;
            if ($urandom % 2) p[22:20] = 3'd0;
            send(SET, p, 5'($urandom), 16'($urandom), int'($urandom % 4), 0);
         end else
            csr_wr(2'($urandom), $urandom);
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule